// File: doc/BRIEF.md
# Multi-Mode Capture Timer with Real-Time Output Port

A 16-bit down-counter with a reload latch. It works as an interval timer, a period meter, an event counter or a continuous high/low pulse-width meter. A 2-bit mode field selects the mode. All external activity enters on a single input pin. That pin is synchronised with two flip-flops before its edges are detected. In the two measurement modes, every active edge does three things: it freezes the current count in a hold register, it reloads the counter from the latch, and it pulses an edge interrupt. When the count steps past zero, the counter reloads and pulses a separate underflow interrupt.

The count source is either a free-running divided main clock or a sub-clock tick supplied from outside. The sub-clock path does not depend on the main prescaler, so counting goes on while the divided main clock is idle. A halt bit freezes the count and keeps its value. A two-bit real-time output port copies its preloaded data to the pins on each underflow, but only while its enable field is 11. If that field changes from 00 to 11 after data has been written, the data is driven at once.

A small byte-wide register interface gives access to the block. Writes and read strobes are plain single-cycle control pulses, and read data is combinational. Nothing in the block streams data, so no back-pressure applies.

Top module: `capture_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x10, which means halted. The counter (addresses 3 and 4), the port data (address 5), `rtp_out`, `irq_uflow` and `irq_edge` are all zero.
- R2: The control register fields are: mode in bits [1:0], edge select in bit 2, source select in bit 3 (1 = `sub_tick`), halt in bit 4 and port enable in bits [6:5]. In mode 00, each count tick decrements the counter. A tick at count 0 reloads the latch value instead, and `irq_uflow` is high for the one cycle after that edge. Writing the latch high byte (address 2) also loads {high, low} into the counter.
- R3: With source select 0, the counter decrements exactly once every 2^PRESC_LOG2 clocks.
- R4: While halt is 1, ticks leave the counter value unchanged.
- R5: In mode 01, a synchronised rising edge of `ext_pin` (edge select 0) or falling edge (edge select 1) reloads the counter from the latch and pulses `irq_edge`. The pulse appears on the third clock edge after the pin changes. The other edge has no effect.
- R6: In modes 01 and 11, the count just before an edge reload is held. Reads of addresses 3 and 4 return this held value until address 4 (the high byte) has been read once.
- R7: In mode 10, the counter decrements on selected edges of `ext_pin`, ignores `sub_tick`, and never pulses `irq_edge`.
- R8: In mode 11, both rising and falling edges capture, reload and pulse `irq_edge`.
- R9: With port enable 11, each underflow copies the port data (address 5, bits [1:0]) to `rtp_out` on the same edge that raises `irq_uflow`. Data written between underflows appears only at the next underflow.
- R10: A control write that changes port enable from 00 to 11 drives `rtp_out` with the port data at once, provided port data has been written since reset. Without such a write, `rtp_out` is unchanged.
- R11: While port enable is not 11, underflows leave `rtp_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (releases the held count on address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| sub_tick | input | 1 | Sub-clock count enable, one cycle per tick |
| ext_pin | input | 1 | External event/measurement input, asynchronous |
| rtp_out | output | 2 | Real-time output port pins |
| irq_uflow | output | 1 | Underflow interrupt pulse |
| irq_edge | output | 1 | Measurement-edge interrupt pulse |

## Verification
Register writes, `sub_tick` ticks and the resulting reload, `irq_uflow` pulse and port update all take effect on the next rising edge. The bench drives every stimulus on a falling edge and samples one nanosecond after the following falling edge. A change on `ext_pin` passes two synchroniser stages and an edge register, so `irq_edge` is sampled on each of the four falling edges after the pin moves. The expected pattern is high on the third sample only. The main-clock divider is checked over a window of exactly 40 edges, bounded by two control writes, so the expected tick count does not depend on the divider's phase.

// File: rtl/ct_pkg.sv
package ct_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_PWHL   = 2'b11
  } ct_mode_e;

  // Packed msb-first: enable[6:5], halt[4], src_sub[3], edge_fall[2], mode[1:0]
  typedef struct packed {
    logic [1:0] port_en;
    logic       halt;
    logic       src_sub;
    logic       edge_fall;
    ct_mode_e   mode;
  } ct_ctrl_t;

  localparam int CTRL_W = $bits(ct_ctrl_t);

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_RLD_LO = 3'd1;
  localparam logic [2:0] ADDR_RLD_HI = 3'd2;
  localparam logic [2:0] ADDR_CNT_LO = 3'd3;
  localparam logic [2:0] ADDR_CNT_HI = 3'd4;
  localparam logic [2:0] ADDR_PORT   = 3'd5;

  localparam logic [1:0] PORT_ON  = 2'b11;
  localparam logic [1:0] PORT_OFF = 2'b00;

endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;
endmodule

// File: rtl/ct_counter_core.sv
module ct_counter_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             capture,
  input  logic             hold_release,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] held,
  output logic             hold_valid,
  output logic             uf_now,
  output logic             irq_uf,
  output logic             irq_cap
);
  logic cap_go;
  logic step;

  assign cap_go = capture & ~load;
  assign step   = tick & ~halt & ~load & ~cap_go;
  assign uf_now = step & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cap_go) begin
      cnt <= reload_val;
    end else if (step) begin
      cnt <= uf_now ? reload_val : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= '0;
      hold_valid <= 1'b0;
    end else if (cap_go) begin
      held       <= cnt;
      hold_valid <= 1'b1;
    end else if (hold_release) begin
      hold_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_uf  <= 1'b0;
      irq_cap <= 1'b0;
    end else begin
      irq_uf  <= uf_now;
      irq_cap <= cap_go;
    end
  end
endmodule

// File: rtl/ct_rtport.sv
module ct_rtport
  import ct_pkg::*;
#(
  parameter int PORT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        en_cur,
  input  logic              en_wr,
  input  logic [1:0]        en_new,
  input  logic              data_wr,
  input  logic [PORT_W-1:0] data_new,
  input  logic              uf_now,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] pins
);
  logic data_seen;
  logic go_now;
  logic go_uf;

  assign go_now = en_wr & (en_cur == PORT_OFF) & (en_new == PORT_ON) & data_seen;
  assign go_uf  = uf_now & (en_cur == PORT_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      data_seen <= 1'b0;
    end else if (data_wr) begin
      data_q    <= data_new;
      data_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                pins <= '0;
    else if (go_now || go_uf)  pins <= data_q;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ct_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRESC_LOG2  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sub_tick,
  input  logic              ext_pin,
  output logic [1:0]        rtp_out,
  output logic              irq_uflow,
  output logic              irq_edge
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int PORT_W = 2;

  ct_ctrl_t          ctrl_q;
  logic [CNT_W-1:0]  latch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  held_q;
  logic [CNT_W-1:0]  cnt_view;
  logic [PORT_W-1:0] port_data;
  logic              hold_valid;
  logic              pin_rise, pin_fall, sel_edge, any_edge;
  logic              main_tick, cnt_tick, capture, uf_now;
  logic              wr_ctrl, wr_lo, wr_hi, wr_port, rel_hold;
  logic              halt_w;
  logic [1:0]        port_en_w;
  ct_ctrl_t          ctrl_next;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_lo    = reg_wr && (reg_addr == ADDR_RLD_LO);
  assign wr_hi    = reg_wr && (reg_addr == ADDR_RLD_HI);
  assign wr_port  = reg_wr && (reg_addr == ADDR_PORT);
  assign rel_hold = reg_rd && (reg_addr == ADDR_CNT_HI);
  assign ctrl_next = ct_ctrl_t'(reg_wdata[CTRL_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '{port_en: 2'b00, halt: 1'b1, src_sub: 1'b0,
                  edge_fall: 1'b0, mode: MODE_TIMER};
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (wr_lo) begin
      latch_q[DATA_W-1:0] <= reg_wdata;
    end else if (wr_hi) begin
      latch_q[CNT_W-1:DATA_W] <= reg_wdata;
    end
  end

  ct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
  );

  ct_prescaler #(.DIV_LOG2(PRESC_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(main_tick)
  );

  assign sel_edge = ctrl_q.edge_fall ? pin_fall : pin_rise;
  assign any_edge = pin_rise | pin_fall;

  always_comb begin
    capture  = 1'b0;
    cnt_tick = ctrl_q.src_sub ? sub_tick : main_tick;
    unique case (ctrl_q.mode)
      MODE_PERIOD: capture  = sel_edge;
      MODE_PWHL:   capture  = any_edge;
      MODE_EVENT:  cnt_tick = sel_edge;
      default:     capture  = 1'b0;
    endcase
  end

  assign halt_w    = ctrl_q.halt;
  assign port_en_w = ctrl_q.port_en;

  ct_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .halt(halt_w),
    .load(wr_hi), .load_val({reg_wdata, latch_q[DATA_W-1:0]}),
    .reload_val(latch_q), .capture(capture), .hold_release(rel_hold),
    .cnt(cnt_q), .held(held_q), .hold_valid(hold_valid),
    .uf_now(uf_now), .irq_uf(irq_uflow), .irq_cap(irq_edge)
  );

  ct_rtport #(.PORT_W(PORT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .en_cur(port_en_w), .en_wr(wr_ctrl),
    .en_new(ctrl_next.port_en), .data_wr(wr_port),
    .data_new(reg_wdata[PORT_W-1:0]), .uf_now(uf_now),
    .data_q(port_data), .pins(rtp_out)
  );

  assign cnt_view = hold_valid ? held_q : cnt_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_RLD_LO: reg_rdata = latch_q[DATA_W-1:0];
      ADDR_RLD_HI: reg_rdata = latch_q[CNT_W-1:DATA_W];
      ADDR_CNT_LO: reg_rdata = cnt_view[DATA_W-1:0];
      ADDR_CNT_HI: reg_rdata = cnt_view[CNT_W-1:DATA_W];
      ADDR_PORT:   reg_rdata = {{(DATA_W-PORT_W){1'b0}}, port_data};
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] latch,
  input logic             irq_uflow,
  input logic             irq_edge,
  input logic             halt,
  input logic             load,
  input logic             capture,
  input logic             hold_valid,
  input logic [1:0]       port_en,
  input logic [1:0]       port_data,
  input logic [1:0]       rtp_out
);
  a_r2_uflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
    irq_uflow |-> cnt == $past(latch));

  a_r2_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_uflow && irq_edge));

  a_r4_halt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load && !capture) |=> $stable(cnt));

  a_r5_capture_reload: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |-> (cnt == $past(latch)) && hold_valid);

  a_r9_port_on_uflow: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_uflow && $past(port_en) == 2'b11) |-> rtp_out == $past(port_data));

  a_r11_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_en) != 2'b11 && port_en != 2'b11) |-> $stable(rtp_out));
endmodule

bind capture_timer ct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .latch(latch_q),
  .irq_uflow(irq_uflow), .irq_edge(irq_edge), .halt(halt_w),
  .load(wr_hi), .capture(capture), .hold_valid(hold_valid),
  .port_en(port_en_w), .port_data(port_data), .rtp_out(rtp_out)
);

// File: tb/test_capture_timer.sv
module test_capture_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sub_tick = 1'b0;
  logic       ext_pin = 1'b0;
  logic [1:0] rtp_out;
  logic       irq_uflow, irq_edge;
  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  capture_timer i_capture_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sub_tick(sub_tick), .ext_pin(ext_pin), .rtp_out(rtp_out),
    .irq_uflow(irq_uflow), .irq_edge(irq_edge)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd3, lo);
    rd(3'd4, hi);
    v = {hi, lo};
  endtask

  task automatic tick();
    @(negedge clk); sub_tick = 1'b1;
    @(negedge clk); sub_tick = 1'b0;
    #1;
  endtask

  // irq_edge seen on the four falling edges after the pin moves, first in bit 0
  task automatic pin_to(input logic v, output logic [3:0] seq);
    @(negedge clk); ext_pin = v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 seq[i] = irq_edge;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c;
    logic [3:0]  s;
    int          e;
    int          ls [6] = '{0, 1, 2, 3, 5, 9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 rtp_out", rtp_out, 0);
    chk("R1 irq_uflow", irq_uflow, 0);
    chk("R1 irq_edge", irq_edge, 0);
    rd(3'd0, b); chk("R1 ctrl", b, 8'h10);
    rd_cnt(c);   chk("R1 counter", c, 0);
    rd(3'd5, b); chk("R1 port data", b, 0);

    // R2 sweep of reload values with sub-clock ticks
    foreach (ls[k]) begin
      wr(3'd0, 8'h18);
      wr(3'd1, ls[k][7:0]);
      wr(3'd2, 8'h00);
      rd_cnt(c); chk("R2 load on high write", c, ls[k]);
      wr(3'd0, 8'h08);
      e = ls[k];
      for (int t = 0; t < 2 * ls[k] + 3; t++) begin
        logic uf;
        uf = (e == 0);
        e  = uf ? ls[k] : e - 1;
        tick();
        chk("R2 irq_uflow", irq_uflow, uf);
        rd_cnt(c); chk("R2 counter", c, e);
      end
    end

    // R4 halt
    rd_cnt(c);
    e = c;
    wr(3'd0, 8'h18);
    for (int t = 0; t < 3; t++) begin
      tick();
      chk("R4 no underflow while halted", irq_uflow, 0);
    end
    rd_cnt(c); chk("R4 count kept", c, e);

    // R3 main clock divider over exactly 40 edges
    wr(3'd1, 8'hE8);
    wr(3'd2, 8'h03);
    wr(3'd0, 8'h00);
    repeat (38) @(negedge clk);
    wr(3'd0, 8'h10);
    rd_cnt(c); chk("R3 divided count", c, 1000 - 10);

    // R5 / R6 period mode, rising edge
    wr(3'd0, 8'h18);
    wr(3'd1, 8'd20);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h09);
    repeat (5) tick();
    pin_to(1'b1, s); chk("R5 rise irq timing", s, 4'b0100);
    rd(3'd3, b); chk("R6 held low", b, 15);
    repeat (2) tick();
    rd(3'd3, b); chk("R6 still held", b, 15);
    rd(3'd4, b); chk("R6 held high", b, 0);
    rd(3'd3, b); chk("R6 released live", b, 18);
    pin_to(1'b0, s); chk("R5 falling ignored", s, 4'b0000);
    rd_cnt(c); chk("R5 no reload on other edge", c, 18);
    wr(3'd0, 8'h0D);
    pin_to(1'b1, s); chk("R5 rising ignored when falling selected", s, 4'b0000);
    pin_to(1'b0, s); chk("R5 falling edge irq", s, 4'b0100);
    rd_cnt(c); chk("R6 held on falling capture", c, 18);
    rd_cnt(c); chk("R5 reloaded", c, 20);

    // R8 pulse-width mode, both edges
    wr(3'd1, 8'd30);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h0B);
    repeat (4) tick();
    pin_to(1'b1, s); chk("R8 rise irq", s, 4'b0100);
    rd_cnt(c); chk("R8 held at rise", c, 26);
    rd_cnt(c); chk("R8 reload at rise", c, 30);
    repeat (3) tick();
    pin_to(1'b0, s); chk("R8 fall irq", s, 4'b0100);
    rd_cnt(c); chk("R8 held at fall", c, 27);
    rd_cnt(c); chk("R8 reload at fall", c, 30);

    // R7 event counting
    wr(3'd0, 8'h0A);
    wr(3'd1, 8'd10);
    wr(3'd2, 8'h00);
    repeat (3) tick();
    rd_cnt(c); chk("R7 sub_tick ignored", c, 10);
    for (int p = 0; p < 4; p++) begin
      pin_to(1'b1, s); chk("R7 no edge irq", s, 4'b0000);
      pin_to(1'b0, s); chk("R7 no edge irq", s, 4'b0000);
    end
    rd_cnt(c); chk("R7 counted edges", c, 6);

    // R10 without written data, then R9 underflow transfer
    wr(3'd0, 8'h78);
    chk("R10 no output before data written", rtp_out, 0);
    wr(3'd5, 8'h02);
    chk("R9 data waits for underflow", rtp_out, 0);
    wr(3'd1, 8'd1);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h68);
    tick();
    chk("R9 no underflow yet", irq_uflow, 0);
    chk("R9 pins unchanged", rtp_out, 0);
    tick();
    chk("R9 underflow", irq_uflow, 1);
    chk("R9 pins on underflow", rtp_out, 2);
    wr(3'd5, 8'h01);
    chk("R9 new data waits", rtp_out, 2);
    tick();
    chk("R9 pins before next underflow", rtp_out, 2);
    tick();
    chk("R9 pins on next underflow", rtp_out, 1);

    // R11 port disabled
    wr(3'd0, 8'h08);
    wr(3'd5, 8'h03);
    tick();
    tick();
    chk("R11 underflow occurred", irq_uflow, 1);
    chk("R11 pins unchanged", rtp_out, 1);

    // R10 immediate output on 00 -> 11
    wr(3'd0, 8'h78);
    chk("R10 immediate output", rtp_out, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule